// File: doc/BRIEF.md
# Dual-Protocol Serial Register Port

This block is a serial slave that gives an external controller read and write access to a small register file. It is sequenced only by edges of the serial clock and by the data and enable lines, so it keeps working while the rest of the chip has no clock. A static select pin picks one of two framings. The first is a two-wire bus with START conditions and a fixed 7-bit device address. The second is a three-wire bus framed by an active-low enable.

Both framings share one shift engine. A transfer carries an 8-bit register sub-address and then one or more data bytes. The register pointer steps forward after every data byte. Each received data byte produces a one-period write strobe with its address and data. Read data comes from an external register file through a combinational address/data pair. The data line is open drain: the block only ever requests a pull-down, and the pull-up provides the high level.

Top module: `dual_serial_regport`

## Requirements
- R1: `bus_sel_i` = 1 selects two-wire framing, and in that mode `en_ni` has no effect. `bus_sel_i` = 0 selects three-wire framing, and in that mode any activity while `en_ni` is high produces no acknowledge and no write strobe.
- R2: In two-wire mode, a falling data line while the clock is high is a START. It restarts byte framing at the next rising clock edge, even in the middle of a byte, and a partly shifted byte produces no strobe.
- R3: In two-wire mode, the first byte is the device address `1110000` followed by the direction bit (1 = read), sent MSB first: 0xE0 for a write, 0xE1 for a read. On a match the block asserts `sda_pd_o` from the falling clock after the 8th bit until the falling clock after the 9th bit.
- R4: In two-wire mode, a non-matching address gets no acknowledge. The block then drives nothing and produces no write strobe until the next START.
- R5: In a write, the byte after the device address is the sub-address, and each following byte is data. Every data byte raises `wr_en_o` for one clock period, from the rising edge of its 8th bit. During that period `wr_addr_o` is the sub-address plus the byte index and `wr_data_o` is the byte. Each byte is acknowledged in two-wire mode.
- R6: After a two-wire read address, the block sends the register at the current pointer, MSB first, changing bits on falling clock edges, and steps the pointer after each byte. A master acknowledge (low) continues the read. A master not-acknowledge releases the line until the next START.
- R7: In three-wire mode, a frame runs while `en_ni` is low. Bits are taken on rising clock edges. The first bit is the direction (1 = read), followed by an 8-bit sub-address. Write frames carry data bytes with no acknowledge, and the block never pulls the line low during them. Read frames have one turnaround clock and then auto-incrementing data bytes.
- R8: In three-wire mode, a rising `en_ni` releases the data line at once and resets framing, so the next frame starts cleanly.
- R9: An active-low `rst_ni` clears the block: no pull-down, no strobe, and a register pointer of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Protocol select: 1 two-wire, 0 three-wire |
| en_ni | input | 1 | Three-wire frame enable, active low |
| scl_i | input | 1 | Serial clock |
| sda_i | input | 1 | Level of the shared data line |
| sda_pd_o | output | 1 | Pull-down request for the data line |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | 8 | Register read address (current pointer) |
| rd_data_i | input | 8 | Register read data for `rd_addr_o` |

## Verification
A START can land on the same rising clock edge at which the engine would otherwise shift a bit into a pending byte. START detection must win over the shift. The bench provokes this twice: once with a repeated START right after the sub-address acknowledge (the normal read setup), and once with a START after four bits of a data byte. A scoreboard then checks that the partial byte produced no strobe and that the restarted frame is acknowledged and writes or returns the values the bench predicts.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DEV,
    PH_SUB,
    PH_WDAT,
    PH_RDAT,
    PH_ACK,
    PH_MACK,
    PH_TURN,
    PH_IGN
  } phase_e;
endpackage

// File: rtl/dsr_start_det.sv
`timescale 1ns/1ps
// START = data falls while clock high; reported as a toggle to the clock domain
module dsr_start_det (
  input  logic rst_ni,
  input  logic two_wire_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_tgl_o
);
  always_ff @(negedge sda_i or negedge rst_ni) begin
    if (!rst_ni)                  start_tgl_o <= 1'b0;
    else if (scl_i && two_wire_i) start_tgl_o <= ~start_tgl_o;
  end
endmodule

// File: rtl/dsr_engine.sv
`timescale 1ns/1ps
module dsr_engine
  import dsr_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1110000
) (
  input  logic          rst_ni,
  input  logic          arst_ni,
  input  logic          two_wire_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_tgl_i,
  input  logic [DW-1:0] rd_data_i,
  output phase_e        ph_o,
  output logic          msb_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] rd_addr_o
);
  localparam int            CW   = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  phase_e        ph_q, nxt_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, ptr_q, wr_addr_q, wr_data_q;
  logic          rw_q, seen_q, wr_en_q;

  logic          start_pend, last_w, wr_fire;
  logic [DW-1:0] byte_w;

  assign start_pend = two_wire_i && (start_tgl_i != seen_q);
  assign byte_w     = {sh_q[DW-2:0], sda_i};
  assign last_w     = (cnt_q == LAST);
  assign wr_fire    = !start_pend && (ph_q == PH_WDAT) && last_w;

  always_ff @(posedge scl_i or negedge arst_ni) begin
    if (!arst_ni) begin
      ph_q   <= PH_IDLE;
      nxt_q  <= PH_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      seen_q <= 1'b0;
    end else if (start_pend) begin
      seen_q <= start_tgl_i;
      ph_q   <= PH_DEV;
      sh_q   <= {{(DW-1){1'b0}}, sda_i};
      cnt_q  <= CW'(1);
    end else begin
      unique case (ph_q)
        PH_IDLE: if (!two_wire_i) begin
          rw_q  <= sda_i;
          ph_q  <= PH_SUB;
          cnt_q <= '0;
        end
        PH_DEV, PH_SUB, PH_WDAT: begin
          sh_q  <= byte_w;
          cnt_q <= cnt_q + CW'(1);
          if (last_w) begin
            cnt_q <= '0;
            case (ph_q)
              PH_DEV: begin
                if (byte_w[DW-1 -: 7] == DEV_ADDR) begin
                  rw_q  <= byte_w[0];
                  ph_q  <= PH_ACK;
                  nxt_q <= byte_w[0] ? PH_RDAT : PH_SUB;
                end else begin
                  ph_q <= PH_IGN;
                end
              end
              PH_SUB: begin
                ptr_q <= byte_w;
                if (two_wire_i) begin
                  ph_q  <= PH_ACK;
                  nxt_q <= PH_WDAT;
                end else begin
                  ph_q <= rw_q ? PH_TURN : PH_WDAT;
                end
              end
              default: begin
                ptr_q <= ptr_q + DW'(1);
                if (two_wire_i) begin
                  ph_q  <= PH_ACK;
                  nxt_q <= PH_WDAT;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          ph_q <= nxt_q;
          cnt_q <= '0;
          if (nxt_q == PH_RDAT) begin
            sh_q  <= rd_data_i;
            ptr_q <= ptr_q + DW'(1);
          end
        end
        PH_TURN: begin
          sh_q  <= rd_data_i;
          ptr_q <= ptr_q + DW'(1);
          cnt_q <= '0;
          ph_q  <= PH_RDAT;
        end
        PH_RDAT: begin
          sh_q  <= {sh_q[DW-2:0], 1'b0};
          cnt_q <= cnt_q + CW'(1);
          if (last_w) begin
            cnt_q <= '0;
            if (two_wire_i) begin
              ph_q <= PH_MACK;
            end else begin
              sh_q  <= rd_data_i;
              ptr_q <= ptr_q + DW'(1);
            end
          end
        end
        PH_MACK: begin
          if (!sda_i) begin
            sh_q  <= rd_data_i;
            ptr_q <= ptr_q + DW'(1);
            ph_q  <= PH_RDAT;
          end else begin
            ph_q <= PH_IGN;
          end
        end
        default: ;
      endcase
    end
  end

  // strobe survives enable release so the register file still sees it
  always_ff @(posedge scl_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= wr_fire;
      if (wr_fire) begin
        wr_addr_q <= ptr_q;
        wr_data_q <= byte_w;
      end
    end
  end

  assign ph_o      = ph_q;
  assign msb_o     = sh_q[DW-1];
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign rd_addr_o = ptr_q;

  AST_START_REFRAME: assert property (@(posedge scl_i) disable iff (!arst_ni)
    start_pend |=> (ph_q == PH_DEV)); // R2
  AST_MISMATCH_IGNORED: assert property (@(posedge scl_i) disable iff (!arst_ni)
    (ph_q == PH_DEV && last_w && !start_pend && byte_w[DW-1 -: 7] != DEV_ADDR) |=> (ph_q == PH_IGN)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge scl_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R5
endmodule

// File: rtl/dsr_sda_drv.sv
`timescale 1ns/1ps
// updates on falling clock so the line is settled before the master samples
module dsr_sda_drv
  import dsr_pkg::*;
(
  input  logic   arst_ni,
  input  logic   scl_i,
  input  phase_e ph_i,
  input  logic   msb_i,
  output logic   pd_o
);
  always_ff @(negedge scl_i or negedge arst_ni) begin
    if (!arst_ni) pd_o <= 1'b0;
    else          pd_o <= (ph_i == PH_ACK) || (ph_i == PH_RDAT && !msb_i);
  end

  AST_DRIVE_ONLY_ACK_OR_READ: assert property (@(posedge scl_i) disable iff (!arst_ni)
    pd_o |-> (ph_i == PH_ACK || ph_i == PH_RDAT)); // R3
endmodule

// File: rtl/dual_serial_regport.sv
`timescale 1ns/1ps
module dual_serial_regport
  import dsr_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1110000
) (
  input  logic          rst_ni,
  input  logic          bus_sel_i,
  input  logic          en_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  logic   arst_n, start_tgl, msb;
  phase_e ph;

  // three-wire framing is held reset while enable is inactive
  assign arst_n = rst_ni & (bus_sel_i | ~en_ni);

  dsr_start_det u_start (
    .rst_ni      (rst_ni),
    .two_wire_i  (bus_sel_i),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_tgl_o (start_tgl)
  );

  dsr_engine #(.DW(DW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .rst_ni      (rst_ni),
    .arst_ni     (arst_n),
    .two_wire_i  (bus_sel_i),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_tgl_i (start_tgl),
    .rd_data_i   (rd_data_i),
    .ph_o        (ph),
    .msb_o       (msb),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .rd_addr_o   (rd_addr_o)
  );

  dsr_sda_drv u_drv (
    .arst_ni (arst_n),
    .scl_i   (scl_i),
    .ph_i    (ph),
    .msb_i   (msb),
    .pd_o    (sda_pd_o)
  );

  AST_3W_WRITE_QUIET: assert property (@(posedge scl_i) disable iff (!arst_n)
    (!bus_sel_i && ph == PH_WDAT) |-> !sda_pd_o); // R7
  AST_EN_RELEASES_LINE: assert property (@(posedge scl_i) disable iff (!rst_ni)
    (!bus_sel_i && en_ni) |-> !sda_pd_o); // R8
endmodule

// File: tb/dual_serial_regport_tb_top.sv
`timescale 1ns/1ps
module dual_serial_regport_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, bus_sel, en_n, scl, m_sda;
  logic       pd, wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  wire        sda;
  assign sda = m_sda & ~pd;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  assign rd_data = mem[rd_addr];

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] q_a[$], q_d[$];
  logic [7:0] pa, pdat;

  dual_serial_regport dut_i (
    .rst_ni(rst_n), .bus_sel_i(bus_sel), .en_ni(en_n), .scl_i(scl), .sda_i(sda),
    .sda_pd_o(pd), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge wr_en) begin
    #1;
    if (q_a.size() == 0) begin
      chk(1'b0, "R4/R1 unexpected write strobe", wr_addr, 0);
    end else begin
      pa = q_a.pop_front();
      pdat = q_d.pop_front();
      chk(wr_addr == pa, "R5 write address", wr_addr, pa);
      chk(wr_data == pdat, "R5 write data", wr_data, pdat);
    end
    mem[wr_addr] = wr_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wt();
    repeat (2) @(posedge clk);
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
    q_a.push_back(a);
    q_d.push_back(d);
    exp_mem[a] = d;
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wt();
    scl = 1'b1; wt();
    r = sda;
    scl = 1'b0; wt();
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wt();
    scl = 1'b1; wt();
    m_sda = 1'b0; wt();
    scl = 1'b0; wt();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wt();
    scl = 1'b1; wt();
    m_sda = 1'b1; wt();
  endtask

  task automatic i2c_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic i2c_rbyte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clk_bit(last, r);
  endtask

  task automatic i2c_write(input logic [7:0] sub, input int n, input logic [7:0] seed);
    logic ack;
    logic [7:0] d;
    i2c_start();
    i2c_wbyte(8'hE0, ack); chk(ack, "R3 write address ack", ack, 1);
    i2c_wbyte(sub, ack);   chk(ack, "R3 sub-address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 13);
      expect_wr(sub + 8'(k), d);
      i2c_wbyte(d, ack); chk(ack, "R5 data ack", ack, 1);
    end
    i2c_stop();
  endtask

  task automatic i2c_read(input logic [7:0] sub, input int n);
    logic ack;
    logic [7:0] d;
    i2c_start();
    i2c_wbyte(8'hE0, ack);
    i2c_wbyte(sub, ack);
    i2c_start();  // repeated START on the sub-address edge pattern
    i2c_wbyte(8'hE1, ack); chk(ack, "R3 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      i2c_rbyte(k == n - 1, d);
      chk(d == exp_mem[sub + 8'(k)], "R6 read data", d, exp_mem[sub + 8'(k)]);
    end
    i2c_stop();
    #1 chk(pd == 1'b0, "R6 released after nack", pd, 0);
  endtask

  task automatic tw_write(input logic [7:0] sub, input int n, input logic [7:0] seed);
    logic r;
    logic [7:0] d;
    scl = 1'b0; en_n = 1'b0; wt();
    clk_bit(1'b0, r);
    for (int i = 7; i >= 0; i--) clk_bit(sub[i], r);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 29);
      expect_wr(sub + 8'(k), d);
      for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    end
    en_n = 1'b1; wt();
  endtask

  task automatic tw_read(input logic [7:0] sub, input int n);
    logic r;
    logic [7:0] d;
    scl = 1'b0; en_n = 1'b0; wt();
    clk_bit(1'b1, r);
    for (int i = 7; i >= 0; i--) clk_bit(sub[i], r);
    clk_bit(1'b1, r);  // turnaround
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        clk_bit(1'b1, r);
        d = {d[6:0], r};
      end
      chk(d == exp_mem[sub + 8'(k)], "R7 three-wire read data", d, exp_mem[sub + 8'(k)]);
    end
    en_n = 1'b1; wt();
  endtask

  initial begin
    logic ack, r;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    rst_n = 1'b0; bus_sel = 1'b1; en_n = 1'b1; scl = 1'b1; m_sda = 1'b1;
    repeat (5) @(posedge clk);
    #1 chk(pd == 1'b0, "R9 reset no pull-down", pd, 0);
    chk(wr_en == 1'b0, "R9 reset no strobe", wr_en, 0);
    chk(rd_addr == 8'h00, "R9 reset pointer", rd_addr, 0);
    @(posedge clk); rst_n = 1'b1; wt();

    // R9: read without sub-address starts at pointer 0
    i2c_start();
    i2c_wbyte(8'hE1, ack); chk(ack, "R3 read address ack after reset", ack, 1);
    i2c_rbyte(1'b1, d);
    chk(d == exp_mem[0], "R9 read from pointer 0", d, exp_mem[0]);
    i2c_stop();

    // R1: enable has no effect in two-wire mode
    en_n = 1'b0;
    i2c_write(8'h20, 3, 8'h3C);
    en_n = 1'b1;
    i2c_write(8'h28, 1, 8'hA7);
    i2c_read(8'h20, 3);
    i2c_read(8'h28, 1);

    // R4: wrong device address
    i2c_start();
    i2c_wbyte(8'hE2, ack); chk(!ack, "R4 no ack on mismatch", ack, 0);
    i2c_wbyte(8'h30, ack); chk(!ack, "R4 sub ignored", ack, 0);
    i2c_wbyte(8'h55, ack); chk(!ack, "R4 data ignored", ack, 0);
    i2c_stop();
    i2c_read(8'h30, 1);

    // R2: START mid data byte drops the partial byte
    i2c_start();
    i2c_wbyte(8'hE0, ack);
    i2c_wbyte(8'h40, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, r);
    i2c_start();
    i2c_wbyte(8'hE0, ack); chk(ack, "R2 ack after restart", ack, 1);
    i2c_wbyte(8'h41, ack);
    expect_wr(8'h41, 8'h5C);
    i2c_wbyte(8'h5C, ack);
    i2c_stop();
    i2c_read(8'h40, 2);

    // R1: three-wire mode ignores activity with enable high
    bus_sel = 1'b0; wt();
    i2c_start();
    i2c_wbyte(8'hE0, ack); chk(!ack, "R1 no ack in three-wire idle", ack, 0);
    i2c_wbyte(8'h90, ack);
    i2c_wbyte(8'h11, ack);
    i2c_stop();

    // R7: three-wire write and read
    tw_write(8'h80, 2, 8'h6B);
    tw_write(8'hFF, 2, 8'h12);  // pointer wraps
    tw_read(8'h80, 2);
    tw_read(8'hFF, 2);

    // R8: enable rise aborts a read while the line is pulled
    scl = 1'b0; en_n = 1'b0; wt();
    clk_bit(1'b1, r);
    for (int i = 7; i >= 0; i--) clk_bit(1'b0, r);
    clk_bit(1'b1, r);
    #1 chk(pd == !exp_mem[0][7], "R8 read MSB driven", pd, !exp_mem[0][7]);
    en_n = 1'b1;
    #1 chk(pd == 1'b0, "R8 release on enable rise", pd, 0);
    wt();
    tw_read(8'h81, 1);

    wt();
    chk(q_a.size() == 0, "R5 all expected writes seen", q_a.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule